// File: doc/BRIEF.md
# Frame Eligibility Controller

This block is the central controller for one input module of a three-stage switch that keeps cells of a flow in order. Cells waiting in the input module are queued by destination output module, not by destination port. The controller keeps a cell count for each of those queues. For every central module it also keeps a credit counter per output link, which is the number of free single-cell internal buffers that link still has.

A queue can be elected only when it holds a whole frame and every central module has a free buffer towards its destination. A whole frame is one cell for each central module. Ties among such queues are broken round-robin, and at most one queue is elected per slot. The elected frame is dispatched in parallel, with frame position r going to central module r. All cells of a frame therefore land in the internal buffers in the same slot, and first-come-first-served output service rebuilds the frame in order.

Cell storage, the central crossbar datapath and output reassembly are outside the block. The block issues the dispatch command and takes credit returns from the central modules.

Top module: `fec_frame_ctrl`

## Requirements
- R1: After reset no grant is issued, no central-module lane is active, no queue is eligible, all cell counts are zero and every credit counter holds BUFS. From reset, BUFS frames to one destination are therefore accepted before any credit comes back.
- R2: Arrival lane p is active when `arr_valid[p]` is 1, and its destination is `arr_om[p*OMW +: OMW]`. In each cycle, the cell count of a queue rises by the number of active lanes naming that queue, including several lanes at once.
- R3: A queue holding fewer than NUM_CM cells is never elected, even when every central module has free buffers.
- R4: `eligible_o[o]` is 1 exactly when queue o holds at least NUM_CM cells and the credit of link o is non-zero in every central module.
- R5: Election is made on the registered state at a clock edge, and `grant_valid` with `grant_om` shows the result in the following cycle. Exactly one grant is issued whenever some queue was eligible, and none otherwise.
- R6: When a grant is issued for destination o, the count of queue o drops by NUM_CM and the credit of link o drops by one in every central module.
- R7: A 1 on `cred_ret[r*NUM_OM+o]` raises the credit of link o in central module r by one. A return in the same cycle as a grant that consumes that credit leaves the credit unchanged. A credit never exceeds BUFS.
- R8: The round-robin search starts at the destination just after the last granted one and wraps from NUM_OM-1 to 0. The first search after reset starts at destination 0.
- R9: With a grant, every bit of `cm_send` is 1 and every lane `cm_om[r*OMW +: OMW]` carries the granted destination, so frame position r goes to central module r. Without a grant, `cm_send` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_valid | input | NUM_PORTS | One cell arrives on lane p |
| arr_om | input | NUM_PORTS*OMW | Destination output module per arrival lane |
| cred_ret | input | NUM_CM*NUM_OM | A cell for link o left central module r (bit r*NUM_OM+o) |
| eligible_o | output | NUM_OM | Queue holds a frame and every central module has room |
| grant_valid | output | 1 | A frame was elected in the previous cycle |
| grant_om | output | OMW | Destination of the elected frame |
| cm_send | output | NUM_CM | Dispatch strobe per central module |
| cm_om | output | NUM_CM*OMW | Destination carried on each central-module lane |

## Verification
The assertions take for granted that a credit return comes only for a buffer that is actually occupied, so a return never arrives while that credit already sits at BUFS. They also take for granted that arrivals never push a queue count past its counter width. The stimulus meets both conditions. It returns credits only where the bench's own credit model shows a shortfall, and it keeps the queued cells to a few frames per destination. Because the checks compare grants against a model written from the requirements, every corner case also needs the stimulus to stay legal: credit exhaustion, a return that coincides with a grant, and a burst that completes a frame in one cycle.

// File: rtl/fec_pkg.sv
package fec_pkg;

  // Index width for a set of n items; never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fec_cell_tally.sv
module fec_cell_tally #(
  parameter int NUM_PORTS = 3,
  parameter int OMW       = 2,
  parameter int CNT_W     = 6,
  parameter int OM_ID     = 0,
  parameter int FRAME     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_PORTS-1:0]     arr_valid,
  input  logic [NUM_PORTS*OMW-1:0] arr_om,
  input  logic                     take,
  output logic [CNT_W-1:0]         count,
  output logic                     full_frame
);

  localparam logic [OMW-1:0]   MY_ID   = OMW'(OM_ID);
  localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME);

  logic [CNT_W-1:0] add;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // number of lanes carrying a cell for this destination
  always_comb begin
    add = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (arr_valid[p] && (arr_om[p*OMW +: OMW] == MY_ID)) begin
        add = add + CNT_W'(1);
      end
    end
  end

  always_comb begin
    cnt_en = (add != '0) || take;
    cnt_d  = cnt_q + add - (take ? FRAME_C : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count      = cnt_q;
  assign full_frame = (cnt_q >= FRAME_C);

endmodule

// File: rtl/fec_credit_cell.sv
module fec_credit_cell #(
  parameter int BUFS = 2,
  parameter int CRW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ret,
  input  logic           take,
  output logic [CRW-1:0] credit,
  output logic           has_room
);

  localparam logic [CRW-1:0] FULL_C = CRW'(BUFS);

  logic [CRW-1:0] cr_q;
  logic [CRW-1:0] cr_d;
  logic           cr_en;

  // a return and a take in the same cycle cancel
  always_comb begin
    cr_en = ret ^ take;
    cr_d  = take ? (cr_q - CRW'(1)) : (cr_q + CRW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q <= FULL_C;
    end else if (cr_en) begin
      cr_q <= cr_d;
    end
  end

  assign credit   = cr_q;
  assign has_room = (cr_q != '0);

endmodule

// File: rtl/fec_rr_pick.sv
module fec_rr_pick #(
  parameter int N = 3,
  parameter int W = 2
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic         win_valid,
  output logic [W-1:0] win_idx
);

  // search begins one past the last winner and wraps
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = int'(ptr) + off;
      if (idx >= N) idx = idx - N;
      if (!win_valid && req[idx]) begin
        win_valid = 1'b1;
        win_idx   = W'(idx);
      end
    end
  end

endmodule

// File: rtl/fec_frame_ctrl.sv
module fec_frame_ctrl #(
  parameter int NUM_CM    = 3,
  parameter int NUM_OM    = 3,
  parameter int NUM_PORTS = 3,
  parameter int BUFS      = 2,
  parameter int CNT_W     = 6,
  parameter int OMW       = fec_pkg::idx_w(NUM_OM)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_PORTS-1:0]     arr_valid,
  input  logic [NUM_PORTS*OMW-1:0] arr_om,
  input  logic [NUM_CM*NUM_OM-1:0] cred_ret,
  output logic [NUM_OM-1:0]        eligible_o,
  output logic                     grant_valid,
  output logic [OMW-1:0]           grant_om,
  output logic [NUM_CM-1:0]        cm_send,
  output logic [NUM_CM*OMW-1:0]    cm_om
);

  localparam int CRW   = fec_pkg::idx_w(BUFS + 1);
  localparam int LINKS = NUM_CM * NUM_OM;

  logic [NUM_OM-1:0]       full_frame;
  logic [NUM_OM-1:0]       take;
  logic [NUM_OM-1:0]       room_all;
  logic [LINKS-1:0]        room;
  logic [NUM_OM*CNT_W-1:0] cnt_all;
  logic [LINKS*CRW-1:0]    cred_all;

  logic           win_valid;
  logic [OMW-1:0] win_idx;

  logic           gv_q, gv_d;
  logic [OMW-1:0] gom_q, gom_d;
  logic [OMW-1:0] ptr_q, ptr_d;
  logic           sel_en;

  // one cell tally per destination queue
  for (genvar o = 0; o < NUM_OM; o++) begin : g_queue
    fec_cell_tally #(
      .NUM_PORTS (NUM_PORTS),
      .OMW       (OMW),
      .CNT_W     (CNT_W),
      .OM_ID     (o),
      .FRAME     (NUM_CM)
    ) u_tally (
      .clk        (clk),
      .rst_n      (rst_n),
      .arr_valid  (arr_valid),
      .arr_om     (arr_om),
      .take       (take[o]),
      .count      (cnt_all[o*CNT_W +: CNT_W]),
      .full_frame (full_frame[o])
    );
  end

  // one credit counter per output link of every central module
  for (genvar r = 0; r < NUM_CM; r++) begin : g_cm
    for (genvar o = 0; o < NUM_OM; o++) begin : g_link
      fec_credit_cell #(
        .BUFS (BUFS),
        .CRW  (CRW)
      ) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .ret      (cred_ret[r*NUM_OM+o]),
        .take     (take[o]),
        .credit   (cred_all[(r*NUM_OM+o)*CRW +: CRW]),
        .has_room (room[r*NUM_OM+o])
      );
    end
  end

  // a destination has room only if every central module has a buffer free
  always_comb begin
    for (int o = 0; o < NUM_OM; o++) begin
      room_all[o] = 1'b1;
      for (int r = 0; r < NUM_CM; r++) begin
        room_all[o] = room_all[o] & room[r*NUM_OM+o];
      end
    end
  end

  assign eligible_o = full_frame & room_all;

  fec_rr_pick #(
    .N (NUM_OM),
    .W (OMW)
  ) u_pick (
    .req       (eligible_o),
    .ptr       (ptr_q),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  always_comb begin
    for (int o = 0; o < NUM_OM; o++) begin
      take[o] = win_valid && (win_idx == OMW'(o));
    end
  end

  // next state of the grant register and round-robin pointer
  always_comb begin
    sel_en = win_valid;
    gv_d   = win_valid;
    gom_d  = win_valid ? win_idx : gom_q;
    ptr_d  = win_valid ? win_idx : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q <= 1'b0;
    end else begin
      gv_q <= gv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gom_q <= '0;
      ptr_q <= OMW'(NUM_OM - 1);
    end else if (sel_en) begin
      gom_q <= gom_d;
      ptr_q <= ptr_d;
    end
  end

  assign grant_valid = gv_q;
  assign grant_om    = gom_q;

  // frame position r goes to central module r
  for (genvar r = 0; r < NUM_CM; r++) begin : g_lane
    assign cm_send[r]            = gv_q;
    assign cm_om[r*OMW +: OMW]   = gom_q;
  end

endmodule

// File: rtl/fec_frame_ctrl_chk.sv
module fec_frame_ctrl_chk #(
  parameter int NUM_CM = 3,
  parameter int NUM_OM = 3,
  parameter int BUFS   = 2,
  parameter int CNT_W  = 6,
  parameter int OMW    = 2,
  parameter int CRW    = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CM*NUM_OM-1:0]       cred_ret,
  input logic [NUM_OM-1:0]              eligible_o,
  input logic                           grant_valid,
  input logic [OMW-1:0]                 grant_om,
  input logic [NUM_OM*CNT_W-1:0]        cnt_all,
  input logic [NUM_CM*NUM_OM*CRW-1:0]   cred_all
);

  // R5
  grant_when_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eligible_o) != '0) |-> grant_valid);

  // R5
  idle_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eligible_o) == '0) |-> !grant_valid);

  for (genvar o = 0; o < NUM_OM; o++) begin : g_q
    // R3
    frame_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && (grant_om == OMW'(o))) |->
        ($past(cnt_all[o*CNT_W +: CNT_W]) >= CNT_W'(NUM_CM)));

    // R4
    grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && (grant_om == OMW'(o))) |-> $past(eligible_o[o]));

    for (genvar r = 0; r < NUM_CM; r++) begin : g_c
      // R6
      credit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && (grant_om == OMW'(o)) && !$past(cred_ret[r*NUM_OM+o])) |->
          (cred_all[(r*NUM_OM+o)*CRW +: CRW] ==
           $past(cred_all[(r*NUM_OM+o)*CRW +: CRW]) - CRW'(1)));

      // R7
      credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cred_all[(r*NUM_OM+o)*CRW +: CRW] <= CRW'(BUFS));

      // R7
      return_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cred_ret[r*NUM_OM+o] |-> (cred_all[(r*NUM_OM+o)*CRW +: CRW] < CRW'(BUFS)));
    end
  end

endmodule

bind fec_frame_ctrl fec_frame_ctrl_chk #(
  .NUM_CM (NUM_CM),
  .NUM_OM (NUM_OM),
  .BUFS   (BUFS),
  .CNT_W  (CNT_W),
  .OMW    (OMW),
  .CRW    (CRW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cred_ret    (cred_ret),
  .eligible_o  (eligible_o),
  .grant_valid (grant_valid),
  .grant_om    (grant_om),
  .cnt_all     (cnt_all),
  .cred_all    (cred_all)
);

// File: tb/fec_frame_ctrl_tb.sv
module fec_frame_ctrl_tb;

  localparam int NUM_CM    = 3;
  localparam int NUM_OM    = 3;
  localparam int NUM_PORTS = 3;
  localparam int BUFS      = 2;
  localparam int CNT_W     = 6;
  localparam int OMW       = fec_pkg::idx_w(NUM_OM);
  localparam int LINKS     = NUM_CM * NUM_OM;

  logic                     clk;
  logic                     rst_n;
  logic [NUM_PORTS-1:0]     arr_valid;
  logic [NUM_PORTS*OMW-1:0] arr_om;
  logic [LINKS-1:0]         cred_ret;
  logic [NUM_OM-1:0]        eligible_o;
  logic                     grant_valid;
  logic [OMW-1:0]           grant_om;
  logic [NUM_CM-1:0]        cm_send;
  logic [NUM_CM*OMW-1:0]    cm_om;

  fec_frame_ctrl #(
    .NUM_CM    (NUM_CM),
    .NUM_OM    (NUM_OM),
    .NUM_PORTS (NUM_PORTS),
    .BUFS      (BUFS),
    .CNT_W     (CNT_W)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .arr_valid   (arr_valid),
    .arr_om      (arr_om),
    .cred_ret    (cred_ret),
    .eligible_o  (eligible_o),
    .grant_valid (grant_valid),
    .grant_om    (grant_om),
    .cm_send     (cm_send),
    .cm_om       (cm_om)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model built from the requirements
  int mcnt  [NUM_OM];
  int mcred [NUM_CM][NUM_OM];
  int mptr;
  bit exp_gv;
  int exp_om;
  int glog [0:255];
  int gn = 0;

  function automatic bit m_elig(input int o);
    if (mcnt[o] < NUM_CM) return 1'b0;
    for (int r = 0; r < NUM_CM; r++) if (mcred[r][o] == 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < NUM_OM; o++) begin
        mcnt[o] = 0;
        for (int r = 0; r < NUM_CM; r++) mcred[r][o] = BUFS;
      end
      mptr   = NUM_OM - 1;
      exp_gv = 1'b0;
      exp_om = 0;
    end else begin
      bit found;
      int w;
      found = 1'b0;
      w     = 0;
      for (int off = 1; off <= NUM_OM; off++) begin
        int idx;
        idx = (mptr + off) % NUM_OM;
        if (!found && m_elig(idx)) begin
          found = 1'b1;
          w     = idx;
        end
      end
      exp_gv = found;
      if (found) begin
        exp_om = w;
        mptr   = w;
        mcnt[w] = mcnt[w] - NUM_CM;
      end
      for (int p = 0; p < NUM_PORTS; p++)
        if (arr_valid[p]) mcnt[int'(arr_om[p*OMW +: OMW])]++;
      for (int r = 0; r < NUM_CM; r++)
        for (int o = 0; o < NUM_OM; o++) begin
          if (cred_ret[r*NUM_OM+o]) mcred[r][o]++;
          if (found && (o == w)) mcred[r][o]--;
        end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(grant_valid == exp_gv, "R5 grant_valid", int'(grant_valid), int'(exp_gv));
      if (exp_gv) chk(int'(grant_om) == exp_om, "R8 grant_om", int'(grant_om), exp_om);
      for (int r = 0; r < NUM_CM; r++) begin
        chk(cm_send[r] == exp_gv, "R9 cm_send lane", int'(cm_send[r]), int'(exp_gv));
        if (exp_gv)
          chk(int'(cm_om[r*OMW +: OMW]) == exp_om, "R9 cm_om lane",
              int'(cm_om[r*OMW +: OMW]), exp_om);
      end
      for (int o = 0; o < NUM_OM; o++)
        chk(eligible_o[o] == m_elig(o), "R4 eligible", int'(eligible_o[o]), int'(m_elig(o)));
      if (grant_valid && gn < 256) begin
        glog[gn] = int'(grant_om);
        gn++;
      end
    end
  end

  task automatic drive(input logic [NUM_PORTS-1:0] v, input int o0, input int o1,
                       input int o2, input logic [LINKS-1:0] ret);
    @(negedge clk);
    arr_valid = v;
    arr_om    = {OMW'(o2), OMW'(o1), OMW'(o0)};
    cred_ret  = ret;
  endtask

  task automatic idle(input int n);
    repeat (n) drive('0, 0, 0, 0, '0);
  endtask

  // return every outstanding credit the model shows
  task automatic drain();
    repeat (BUFS + 2) begin
      @(negedge clk);
      arr_valid = '0;
      for (int r = 0; r < NUM_CM; r++)
        for (int o = 0; o < NUM_OM; o++)
          cred_ret[r*NUM_OM+o] = (mcred[r][o] < BUFS);
    end
    idle(3);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(grant_valid == 1'b0, "R1 no grant after reset", int'(grant_valid), 0);
    chk(cm_send == '0, "R1 lanes idle after reset", int'(cm_send), 0);
    chk(eligible_o == '0, "R1 nothing eligible after reset", int'(eligible_o), 0);
  endtask

  task automatic t_short_frame();
    int g0;
    g0 = gn;
    drive(3'b011, 1, 1, 0, '0);
    idle(4);
    chk(eligible_o == '0, "R3 short queue not eligible", int'(eligible_o), 0);
    chk(gn == g0, "R3 short queue not granted", gn - g0, 0);
    drive(3'b100, 0, 0, 1, '0);
    idle(1);
    chk(eligible_o[1] == 1'b1, "R2 third cell completes frame", int'(eligible_o[1]), 1);
    idle(1);
    chk(grant_valid && grant_om == OMW'(1), "R5 grant follows eligibility",
        int'(grant_om), 1);
    chk(cm_send == '1, "R9 all lanes dispatch", int'(cm_send), (1 << NUM_CM) - 1);
    drain();
  endtask

  task automatic t_credit();
    int g0;
    g0 = gn;
    drive(3'b111, 0, 0, 0, '0);
    drive(3'b111, 0, 0, 0, '0);
    drive(3'b111, 0, 0, 0, '0);
    idle(3);
    // R1: full credit of BUFS lets exactly BUFS frames through
    chk(gn - g0 == BUFS, "R1 frames accepted on initial credit", gn - g0, BUFS);
    chk(eligible_o[0] == 1'b0, "R6 credit exhausted blocks frame", int'(eligible_o[0]), 0);
    drive('0, 0, 0, 0, LINKS'(9'b000_001_001));
    idle(2);
    chk(eligible_o[0] == 1'b0, "R4 partial return still blocks", int'(eligible_o[0]), 0);
    drive('0, 0, 0, 0, LINKS'(9'b001_000_000));
    idle(1);
    chk(eligible_o[0] == 1'b1, "R7 last return unblocks", int'(eligible_o[0]), 1);
    idle(1);
    chk(grant_valid && grant_om == OMW'(0), "R6 blocked frame granted", int'(grant_om), 0);
    drain();
  endtask

  task automatic t_round_robin();
    int g0;
    g0 = gn;
    drive(3'b111, 0, 1, 2, '0);
    drive(3'b111, 0, 1, 2, '0);
    drive(3'b111, 0, 1, 2, '0);
    idle(5);
    // R8: last grant went to 0, so the order is 1, 2, 0
    chk(gn - g0 == 3, "R8 three grants", gn - g0, 3);
    chk(glog[g0] == 1, "R8 first winner", glog[g0], 1);
    chk(glog[g0+1] == 2, "R8 second winner", glog[g0+1], 2);
    chk(glog[g0+2] == 0, "R8 wrap winner", glog[g0+2], 0);
    drain();
  endtask

  task automatic t_burst();
    drive(3'b111, 2, 2, 2, '0);
    idle(1);
    chk(eligible_o[2] == 1'b1, "R2 three lanes one queue", int'(eligible_o[2]), 1);
    idle(1);
    chk(grant_valid && grant_om == OMW'(2), "R5 burst frame granted", int'(grant_om), 2);
    drain();
  endtask

  task automatic t_simul();
    drive(3'b111, 1, 1, 1, '0);
    idle(1);
    drive(3'b111, 1, 1, 1, '0);
    drive('0, 0, 0, 0, LINKS'(9'b010_010_010));
    drive(3'b111, 1, 1, 1, '0);
    idle(1);
    chk(eligible_o[1] == 1'b1, "R7 return with grant keeps credit", int'(eligible_o[1]), 1);
    drive(3'b111, 1, 1, 1, '0);
    idle(1);
    chk(eligible_o[1] == 1'b0, "R6 last credit consumed", int'(eligible_o[1]), 0);
    drain();
    drain();
  endtask

  initial begin
    rst_n     = 1'b0;
    arr_valid = '0;
    arr_om    = '0;
    cred_ret  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_short_frame();
    t_credit();
    t_round_robin();
    t_burst();
    t_simul();
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule